// File: doc/BRIEF.md
# Keyed unlock sequencer

This block sits behind one write-only control register and decides whether a protected information region may be touched. Software opens the region by writing three fixed 32-bit keys to the register, one after another and in a fixed order. When the last key lands, a single access-enable output goes high, and the surrounding logic uses it to gate every read and write of the protected region. While access is open, the next write of any value closes it again. Reads of the register never reveal progress or keys: they return zero.

Inside, a small state machine with three named states tracks progress. **S_LOCKED** means no key has matched. **S_ARMED** means one or more leading keys have matched and a step counter names the next expected key. **S_OPEN** means the region is unlocked. Each cycle one of six named transitions is chosen:
- **T_HOLD**: no write this cycle.
- **T_ADVANCE**: the expected key was written and it was not the last one.
- **T_GRANT**: the last key was written.
- **T_RESYNC**: a wrong value was written, but it equals the first key, so it counts as step one.
- **T_RESTART**: a wrong value was written.
- **T_REVOKE**: any write while in S_OPEN.

The key values and the key count are parameters. The defaults, in the order they must be written, are 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1. The key count must be at least two.

Top module: `keyed_unlock`

## Requirements
- R1: After reset, and after any reset in the middle of a sequence, `access_en` is 0 and no key counts as matched. A full three-key sequence is needed before access opens.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 (each a cycle with `wr_en`=1) raises `access_en`.
- R3: A write that is neither the expected next key nor the first key sends the sequencer back to S_LOCKED (T_RESTART). The keys written before it no longer count.
- R4: A wrong write that equals the first key 0x3A7F5CA3 counts as step one (T_RESYNC). The second and third keys then complete the unlock.
- R5: In S_OPEN, a write of any value drops `access_en` in the cycle after that write (T_REVOKE).
- R6: The write that revokes access is not counted as a key, even when its value is 0x3A7F5CA3. It must be followed by all three keys to reopen.
- R7: `rd_data` is zero in every state and every cycle.
- R8: Cycles with `wr_en`=0 change nothing (T_HOLD), whatever `wr_data` carries. This holds both while a sequence is in progress and while access is open.
- R9: `access_en` rises only in the cycle right after the clock edge that accepted the last key. A rising edge is never preceded by anything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the key register |
| wr_data | input | DATA_W | Value written to the key register |
| rd_data | output | DATA_W | Readback of the key register, always zero |
| access_en | output | 1 | High while the protected region is unlocked |

## Verification
The bench builds the block with its default parameters: 32-bit data, three keys, and the three default key values. With three keys the step counter visits every non-final step, so both T_ADVANCE and T_GRANT occur. With these defaults a resync on the first key can be provoked at step one as well as at step two. The two-bit step counter also has one code that is never reached, and the checker confirms that an out-of-order final key never opens access.

// File: rtl/keyed_unlock_pkg.sv
package keyed_unlock_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        S_LOCKED = 2'd0,
        S_ARMED  = 2'd1,
        S_OPEN   = 2'd2
    } kul_state_e;

    // Transition chosen in a cycle
    typedef enum logic [2:0] {
        T_HOLD    = 3'd0,
        T_ADVANCE = 3'd1,
        T_GRANT   = 3'd2,
        T_RESTART = 3'd3,
        T_RESYNC  = 3'd4,
        T_REVOKE  = 3'd5
    } kul_move_e;

endpackage

// File: rtl/kul_key_cmp.sv
module kul_key_cmp #(
    parameter int DATA_W   = 32,
    parameter int NUM_KEYS = 3,
    parameter int STEP_W   = 2,
    parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ = '0
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STEP_W-1:0] step,
    output logic              hit_expected,
    output logic              hit_first
);

    localparam int SLOTS = 1 << STEP_W;

    logic [SLOTS-1:0] eq;

    // One comparator per key; unused step codes never match
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_KEYS) begin : g_key
            assign eq[i] = (wr_data == KEY_SEQ[i*DATA_W +: DATA_W]);
        end else begin : g_pad
            assign eq[i] = 1'b0;
        end
    end

    assign hit_expected = eq[step];
    assign hit_first    = eq[0];

endmodule

// File: rtl/kul_seq_fsm.sv
module kul_seq_fsm
    import keyed_unlock_pkg::*;
#(
    parameter int NUM_KEYS = 3,
    parameter int STEP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hit_expected,
    input  logic              hit_first,
    output logic [STEP_W-1:0] step,
    output logic              access_en
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);
    localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

    kul_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    kul_move_e         move;
    logic              access_q;

    // Pick this cycle's transition
    always_comb begin
        move = T_HOLD;
        unique case (state_q)
            S_LOCKED, S_ARMED: begin
                if (wr_en) begin
                    if (hit_expected) begin
                        move = (step_q == LAST_STEP) ? T_GRANT : T_ADVANCE;
                    end else if (hit_first) begin
                        move = T_RESYNC;
                    end else begin
                        move = T_RESTART;
                    end
                end
            end
            S_OPEN: begin
                if (wr_en) begin
                    move = T_REVOKE;
                end
            end
            default: move = T_RESTART;
        endcase
    end

    // Apply the transition
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (move)
            T_HOLD: begin
            end
            T_ADVANCE: begin
                state_d = S_ARMED;
                step_d  = step_q + ONE_STEP;
            end
            T_GRANT: begin
                state_d = S_OPEN;
                step_d  = '0;
            end
            T_RESYNC: begin
                state_d = S_ARMED;
                step_d  = ONE_STEP;
            end
            T_RESTART, T_REVOKE: begin
                state_d = S_LOCKED;
                step_d  = '0;
            end
            default: begin
                state_d = S_LOCKED;
                step_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOCKED;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            access_q <= 1'b0;
        end else begin
            access_q <= (state_d == S_OPEN);
        end
    end

    assign step      = step_q;
    assign access_en = access_q;

endmodule

// File: rtl/keyed_unlock.sv
module keyed_unlock #(
    parameter int DATA_W   = 32,
    parameter int NUM_KEYS = 3,
    parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ =
        {32'h9608B2C1, 32'hA1E34F20, 32'h3A7F5CA3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              access_en
);

    localparam int STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

    logic [STEP_W-1:0] key_step;
    logic              hit_expected;
    logic              hit_first;

    kul_key_cmp #(
        .DATA_W   (DATA_W),
        .NUM_KEYS (NUM_KEYS),
        .STEP_W   (STEP_W),
        .KEY_SEQ  (KEY_SEQ)
    ) u_cmp (
        .wr_data      (wr_data),
        .step         (key_step),
        .hit_expected (hit_expected),
        .hit_first    (hit_first)
    );

    kul_seq_fsm #(
        .NUM_KEYS (NUM_KEYS),
        .STEP_W   (STEP_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .hit_expected (hit_expected),
        .hit_first    (hit_first),
        .step         (key_step),
        .access_en    (access_en)
    );

    // Readback never exposes keys or progress
    assign rd_data = '0;

endmodule

// File: rtl/keyed_unlock_chk.sv
module keyed_unlock_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_KEYS = 3,
    parameter int STEP_W   = 2,
    parameter logic [NUM_KEYS*DATA_W-1:0] KEY_SEQ = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              access_en,
    input logic [STEP_W-1:0] key_step
);

    localparam logic [DATA_W-1:0] FIRST_KEY = KEY_SEQ[DATA_W-1:0];
    localparam logic [DATA_W-1:0] LAST_KEY  = KEY_SEQ[(NUM_KEYS-1)*DATA_W +: DATA_W];
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);

    logic [DATA_W-1:0] expected_key;
    assign expected_key = KEY_SEQ[int'(key_step)*DATA_W +: DATA_W];

    // R9: a rise of access follows only an accepted last-key write
    a_r9_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> ($past(wr_en) && $past(wr_data) == LAST_KEY
                              && $past(key_step) == LAST_STEP));

    // R5: any write while open closes access next cycle
    a_r5_revoke: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && wr_en) |=> !access_en);

    // R6: the revoking write leaves no key matched
    a_r6_revoke_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && wr_en) |=> (key_step == '0));

    // R8: idle cycles keep access and progress unchanged
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(access_en) && $stable(key_step)));

    // R3: unrelated wrong value restarts the sequence
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !access_en && wr_data != expected_key && wr_data != FIRST_KEY)
        |=> (key_step == '0 && !access_en));

    // R4: wrong value equal to the first key counts as step one
    a_r4_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !access_en && wr_data != expected_key && wr_data == FIRST_KEY)
        |=> (key_step == STEP_W'(1) && !access_en));

    // R1: progress stays within the key count
    a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (key_step <= LAST_STEP));

endmodule

bind keyed_unlock keyed_unlock_chk #(
    .DATA_W   (DATA_W),
    .NUM_KEYS (NUM_KEYS),
    .STEP_W   (STEP_W),
    .KEY_SEQ  (KEY_SEQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .access_en (access_en),
    .key_step  (key_step)
);

// File: tb/tb_keyed_unlock.sv
module tb_keyed_unlock;

    localparam logic [31:0] K0 = 32'h3A7F5CA3;
    localparam logic [31:0] K1 = 32'hA1E34F20;
    localparam logic [31:0] K2 = 32'h9608B2C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        access_en;

    int checks = 0;
    int fails  = 0;

    // Reference model: the list of keys still owed, and the open flag
    logic [31:0] owed[$];
    bit          m_open;

    always #2 clk = ~clk;

    keyed_unlock dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .access_en (access_en)
    );

    task automatic model_clear();
        owed   = '{K0, K1, K2};
        m_open = 1'b0;
    endtask

    task automatic model_write(input logic [31:0] d);
        if (m_open) begin
            m_open = 1'b0;
            model_clear();
        end else if (d == owed[0]) begin
            void'(owed.pop_front());
            if (owed.size() == 0) begin
                model_clear();
                m_open = 1'b1;
            end
        end else begin
            model_clear();
            if (d == K0) void'(owed.pop_front());
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check(access_en == m_open, {tag, " access_en"}, 32'(access_en), 32'(m_open));
        check(rd_data == '0, "R7 rd_data zero", rd_data, 32'h0);
    endtask

    // Entered at a falling edge, leaves at the next falling edge
    task automatic cyc(input logic we, input logic [31:0] d, input string tag);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        if (we) model_write(d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_clear();
        rst_n = 1'b1;
        compare("R1 reset");
    endtask

    task automatic unlock(input string tag);
        cyc(1'b1, K0, tag);
        cyc(1'b1, K1, tag);
        cyc(1'b1, K2, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        check(access_en == 1'b0, "R1 locked after reset", 32'(access_en), 32'h0);

        // R2 / R9: plain unlock, opens the cycle after the last key
        cyc(1'b1, K0, "R2 key0");
        cyc(1'b1, K1, "R2 key1");
        check(access_en == 1'b0, "R9 still closed before last key", 32'(access_en), 32'h0);
        cyc(1'b1, K2, "R2 key2");
        check(access_en == 1'b1, "R2 open after three keys", 32'(access_en), 32'h1);

        // R8: idle while open, noisy data
        cyc(1'b0, 32'hFFFF_FFFF, "R8 idle open");
        cyc(1'b0, K0, "R8 idle open");
        check(access_en == 1'b1, "R8 stays open", 32'(access_en), 32'h1);

        // R5: any write relocks
        cyc(1'b1, 32'h0000_0000, "R5 revoke");
        check(access_en == 1'b0, "R5 closed after write", 32'(access_en), 32'h0);

        // R6: revoke with K0 is not step one
        unlock("R6 reopen");
        cyc(1'b1, K0, "R6 revoke with key0");
        cyc(1'b1, K1, "R6 key1 after revoke");
        cyc(1'b1, K2, "R6 key2 after revoke");
        check(access_en == 1'b0, "R6 no open from revoke write", 32'(access_en), 32'h0);
        cyc(1'b1, 32'h1234_5678, "R3 clear");

        // R3: wrong value mid-sequence
        cyc(1'b1, K0, "R3 key0");
        cyc(1'b1, 32'hDEAD_BEEF, "R3 wrong");
        cyc(1'b1, K1, "R3 key1");
        cyc(1'b1, K2, "R3 key2");
        check(access_en == 1'b0, "R3 restart after wrong at step1", 32'(access_en), 32'h0);
        cyc(1'b1, K0, "R3 key0");
        cyc(1'b1, K1, "R3 key1");
        cyc(1'b1, K1, "R3 wrong at step2");
        cyc(1'b1, K2, "R3 key2");
        check(access_en == 1'b0, "R3 restart after wrong at step2", 32'(access_en), 32'h0);
        cyc(1'b1, K2, "R3 last key alone");
        cyc(1'b1, K1, "R3 out of order");
        check(access_en == 1'b0, "R3 out of order stays closed", 32'(access_en), 32'h0);

        // R4: resync on K0 at step one and at step two
        cyc(1'b1, K0, "R4 key0");
        cyc(1'b1, K0, "R4 key0 repeat");
        cyc(1'b1, K1, "R4 key1");
        cyc(1'b1, K2, "R4 key2");
        check(access_en == 1'b1, "R4 open after resync at step1", 32'(access_en), 32'h1);
        cyc(1'b1, 32'h5555_AAAA, "R5 revoke");
        cyc(1'b1, K0, "R4 key0");
        cyc(1'b1, K1, "R4 key1");
        cyc(1'b1, K0, "R4 key0 at step2");
        cyc(1'b1, K1, "R4 key1");
        cyc(1'b1, K2, "R4 key2");
        check(access_en == 1'b1, "R4 open after resync at step2", 32'(access_en), 32'h1);
        cyc(1'b1, K2, "R5 revoke with key2");
        check(access_en == 1'b0, "R5 revoke with last key", 32'(access_en), 32'h0);

        // R8: idle gaps inside a sequence
        cyc(1'b1, K0, "R8 key0");
        cyc(1'b0, 32'hBAD0_BAD0, "R8 idle");
        cyc(1'b1, K1, "R8 key1");
        cyc(1'b0, K0, "R8 idle with key0 data");
        cyc(1'b0, K2, "R8 idle with key2 data");
        check(access_en == 1'b0, "R8 idle key2 ignored", 32'(access_en), 32'h0);
        cyc(1'b1, K2, "R8 key2");
        check(access_en == 1'b1, "R8 open across idle gaps", 32'(access_en), 32'h1);

        // R1: reset while open and mid-sequence
        do_reset();
        check(access_en == 1'b0, "R1 reset closes access", 32'(access_en), 32'h0);
        cyc(1'b1, K0, "R1 key0");
        cyc(1'b1, K1, "R1 key1");
        do_reset();
        cyc(1'b1, K2, "R1 key2 after reset");
        check(access_en == 1'b0, "R1 progress lost on reset", 32'(access_en), 32'h0);
        unlock("R1 full sequence after reset");
        check(access_en == 1'b1, "R1 open after fresh sequence", 32'(access_en), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule